// File: doc/BRIEF.md
# Logical Immediate Bitmask Decoder

This block turns the packed 13-bit form of a logical immediate (one width-select bit, a 6-bit run-length field and a 6-bit rotate field) into the full 64-bit mask that a bitwise AND, OR or XOR would use. It works in four steps. First it finds the repeating element width from a leading-one search. Then it builds a run of ones at the bottom of the element and rotates that run right inside the element. Finally it repeats the element until all 64 bits are filled. Encodings that are reserved are reported on an illegal flag.

The decoder sits in an instruction decode path. A valid strobe travels with each encoding. The parameter `OUT_REG` selects between a purely combinational result and a result held in one output register stage. The instruction that consumes the mask, the register reads and the writeback all lie outside this block.

Top module: `lgimm_mask_dec`

## Requirements
- R1: The width-select bit is placed above the bitwise inverse of the run-length field to form a 7-bit word. The position of the highest set bit of that word is the exponent `k`, and the element width is 2^k bits.
- R2: If no bit above bit 0 of the 7-bit word is set (`k` < 1), `bad_enc_o` is 1 and `mask_o` is all zeros.
- R3: If the run-length field ANDed with (2^k − 1) equals 2^k − 1, `bad_enc_o` is 1 and `mask_o` is all zeros. A legal mask is never all zeros and never all ones.
- R4: For a legal encoding, one element holds s+1 ones in its low bits, where s is the run-length field ANDed with (2^k − 1). This run is rotated right by r inside the element, and `bad_enc_o` is 0.
- R5: The element is repeated across all 64 bits. Bit i of `mask_o` equals bit (i mod 2^k) of the element, so every element narrower than 64 bits gives equal upper and lower 32-bit halves.
- R6: With `OUT_REG`=1, `out_vld`, `mask_o` and `bad_enc_o` show the result for the inputs presented one clock edge earlier. With `OUT_REG`=0, they follow the inputs within the same cycle.
- R7: While `rst_n` is low and `OUT_REG`=1, `out_vld`, `bad_enc_o` and `mask_o` are 0.
- R8: The rotate amount r is the rotate field ANDed with (2^k − 1). Rotate-field bits at or above bit k have no effect on `mask_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Marks the encoding on the inputs as valid |
| wide_sel | input | 1 | Width-select bit of the encoding |
| run_fld | input | 6 | Run-length field of the encoding |
| rot_fld | input | 6 | Rotate field of the encoding |
| out_vld | output | 1 | Valid strobe aligned with the result |
| mask_o | output | 64 | Decoded 64-bit mask, zero when illegal |
| bad_enc_o | output | 1 | Set for a reserved encoding |

## Verification
The bench goes after the edges of the size search. The 2-bit element case exposes a search that returns the wrong exponent: it would yield a wrong period instead of 0x5555…. The reserved `k`=0 codes are also targeted, and a decoder that skipped them would emit a mask rather than flag an error. All-ones runs at each width are tested; a missed width would produce a mask of all ones. The bench also uses rotate fields with bits set above the element width, so a rotation taken modulo 64 instead of modulo the element width shows up as a shifted pattern. An exhaustive sweep of all 8192 encodings, checked against an arithmetic model written independently of the design, catches any slip in rotation direction or in replication.

// File: rtl/lgimm_pkg.sv
package lgimm_pkg;
  localparam int MASK_W = 64;
  localparam int FLD_W  = 6;
  localparam int EXP_W  = 3;
  localparam int SRCH_W = FLD_W + 1;

  // position of the highest set bit of the search word
  function automatic logic [EXP_W-1:0] top_one(input logic [SRCH_W-1:0] v);
    logic [EXP_W-1:0] p;
    p = '0;
    for (int i = 0; i < SRCH_W; i++) begin
      if (v[i]) p = EXP_W'(i);
    end
    return p;
  endfunction

  // all-ones mask below the element width
  function automatic logic [FLD_W-1:0] level_of(input logic [EXP_W-1:0] k);
    logic [FLD_W:0] one_hot;
    one_hot = (FLD_W+1)'(1) << k;
    return FLD_W'(one_hot - 1'b1);
  endfunction

  // low-order run of s+1 ones
  function automatic logic [MASK_W-1:0] run_of(input logic [FLD_W-1:0] s);
    logic [MASK_W-1:0] v;
    for (int j = 0; j < MASK_W; j++) begin
      v[j] = (FLD_W'(j) <= s) && (j < MASK_W);
    end
    return v;
  endfunction

  // rotate right by r inside an element of width lvl+1, zero above it
  function automatic logic [MASK_W-1:0] rot_in_elem(input logic [MASK_W-1:0] run,
                                                   input logic [FLD_W-1:0]  r,
                                                   input logic [FLD_W-1:0]  lvl);
    logic [MASK_W-1:0] v;
    logic [FLD_W-1:0]  src;
    for (int j = 0; j < MASK_W; j++) begin
      src  = (FLD_W'(j) + r) & lvl;
      v[j] = (FLD_W'(j) <= lvl) ? run[src] : 1'b0;
    end
    return v;
  endfunction

  // copy element bit (i & lvl) into every bit i
  function automatic logic [MASK_W-1:0] tile(input logic [MASK_W-1:0] elem,
                                             input logic [FLD_W-1:0]  lvl);
    logic [MASK_W-1:0] v;
    for (int i = 0; i < MASK_W; i++) begin
      v[i] = elem[FLD_W'(i) & lvl];
    end
    return v;
  endfunction
endpackage

// File: rtl/lgimm_size_det.sv
module lgimm_size_det
  import lgimm_pkg::*;
(
  input  logic             wide_sel,
  input  logic [FLD_W-1:0] run_fld,
  output logic [EXP_W-1:0] exp_k,
  output logic [FLD_W-1:0] lvl,
  output logic             size_rsv
);
  logic [SRCH_W-1:0] srch;

  assign srch     = {wide_sel, ~run_fld};
  assign exp_k    = top_one(srch);
  assign lvl      = level_of(exp_k);
  assign size_rsv = (srch[SRCH_W-1:1] == '0);
endmodule

// File: rtl/lgimm_elem_gen.sv
module lgimm_elem_gen
  import lgimm_pkg::*;
(
  input  logic [FLD_W-1:0]  run_fld,
  input  logic [FLD_W-1:0]  rot_fld,
  input  logic [FLD_W-1:0]  lvl,
  output logic [MASK_W-1:0] elem,
  output logic              run_full
);
  logic [FLD_W-1:0]  s_len;
  logic [FLD_W-1:0]  r_amt;
  logic [MASK_W-1:0] run;

  assign s_len    = run_fld & lvl;
  assign r_amt    = rot_fld & lvl;
  assign run_full = (s_len == lvl);
  assign run      = run_of(s_len);
  assign elem     = rot_in_elem(run, r_amt, lvl);
endmodule

// File: rtl/lgimm_replicate.sv
module lgimm_replicate
  import lgimm_pkg::*;
(
  input  logic [MASK_W-1:0] elem,
  input  logic [FLD_W-1:0]  lvl,
  output logic [MASK_W-1:0] filled
);
  assign filled = tile(elem, lvl);
endmodule

// File: rtl/lgimm_mask_dec.sv
module lgimm_mask_dec
  import lgimm_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic              wide_sel,
  input  logic [FLD_W-1:0]  run_fld,
  input  logic [FLD_W-1:0]  rot_fld,
  output logic              out_vld,
  output logic [MASK_W-1:0] mask_o,
  output logic              bad_enc_o
);
  logic [EXP_W-1:0]  exp_c;
  logic [FLD_W-1:0]  lvl_c;
  logic              size_rsv;
  logic              run_full;
  logic [MASK_W-1:0] elem_c;
  logic [MASK_W-1:0] tiled_c;
  logic              illegal_c;
  logic [MASK_W-1:0] mask_c;

  lgimm_size_det u_size (
    .wide_sel (wide_sel),
    .run_fld  (run_fld),
    .exp_k    (exp_c),
    .lvl      (lvl_c),
    .size_rsv (size_rsv)
  );

  lgimm_elem_gen u_elem (
    .run_fld  (run_fld),
    .rot_fld  (rot_fld),
    .lvl      (lvl_c),
    .elem     (elem_c),
    .run_full (run_full)
  );

  lgimm_replicate u_rep (
    .elem   (elem_c),
    .lvl    (lvl_c),
    .filled (tiled_c)
  );

  assign illegal_c = size_rsv | run_full;
  assign mask_c    = illegal_c ? '0 : tiled_c;

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_vld   <= 1'b0;
          mask_o    <= '0;
          bad_enc_o <= 1'b0;
        end else begin
          out_vld   <= in_vld;
          mask_o    <= mask_c;
          bad_enc_o <= illegal_c;
        end
      end
    end else begin : g_comb
      assign out_vld   = in_vld;
      assign mask_o    = mask_c;
      assign bad_enc_o = illegal_c;
    end
  endgenerate
endmodule

// File: rtl/lgimm_mask_dec_chk.sv
module lgimm_mask_dec_chk
  import lgimm_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic              out_vld,
  input logic [MASK_W-1:0] mask_o,
  input logic              bad_enc_o,
  input logic [EXP_W-1:0]  exp_c,
  input logic              size_rsv,
  input logic              illegal_c,
  input logic [MASK_W-1:0] mask_c
);
  p_bad_mask_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_enc_o |-> (mask_o == '0));

  p_rsv_flagged_r2: assert property (@(posedge clk) disable iff (!rst_n)
    size_rsv |-> illegal_c);

  p_legal_not_flat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal_c |-> (mask_c != '0 && mask_c != '1));

  p_halves_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!illegal_c && exp_c != EXP_W'(FLD_W)) |-> (mask_c[63:32] == mask_c[31:0]));

  generate
    if (OUT_REG) begin : g_seq
      p_vld_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
      p_vld_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    end else begin : g_cmb
      p_vld_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == in_vld);
    end
  endgenerate
endmodule

bind lgimm_mask_dec lgimm_mask_dec_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_vld    (in_vld),
  .out_vld   (out_vld),
  .mask_o    (mask_o),
  .bad_enc_o (bad_enc_o),
  .exp_c     (exp_c),
  .size_rsv  (size_rsv),
  .illegal_c (illegal_c),
  .mask_c    (mask_c)
);

// File: tb/test_lgimm_mask_dec.sv
module test_lgimm_mask_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic        wide_sel = 1'b0;
  logic [5:0]  run_fld = '0;
  logic [5:0]  rot_fld = '0;
  logic        out_vld;
  logic [63:0] mask_o;
  logic        bad_enc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lgimm_mask_dec #(.OUT_REG(1'b1)) i_lgimm_mask_dec (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .wide_sel(wide_sel),
    .run_fld(run_fld), .rot_fld(rot_fld), .out_vld(out_vld),
    .mask_o(mask_o), .bad_enc_o(bad_enc_o)
  );

  // {wide_sel, run_fld, rot_fld, bad, mask}
  localparam int NV = 10;
  localparam logic [77:0] VEC [NV] = '{
    {1'b1, 6'b000000, 6'd0,  1'b0, 64'h0000000000000001},
    {1'b0, 6'b111100, 6'd0,  1'b0, 64'h5555555555555555},
    {1'b0, 6'b111101, 6'd0,  1'b1, 64'h0},
    {1'b0, 6'b111110, 6'd0,  1'b1, 64'h0},
    {1'b0, 6'b111111, 6'd5,  1'b1, 64'h0},
    {1'b0, 6'b000111, 6'd4,  1'b0, 64'hF000000FF000000F},
    {1'b1, 6'b111110, 6'd1,  1'b0, 64'hBFFFFFFFFFFFFFFF},
    {1'b1, 6'd63,     6'd0,  1'b1, 64'h0},
    {1'b0, 6'b100011, 6'd50, 1'b0, 64'hC003C003C003C003},
    {1'b0, 6'b110011, 6'd0,  1'b0, 64'h0F0F0F0F0F0F0F0F}
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1:    return "R1";
      3, 4:    return "R2";
      2, 7:    return "R3";
      5, 6:    return "R4";
      8:       return "R8";
      default: return "R5";
    endcase
  endfunction

  // independent arithmetic model
  task automatic model(input logic n, input logic [5:0] s6, input logic [5:0] r6,
                       output logic bad, output logic [63:0] m);
    logic [6:0] w;
    int k, e, s, r;
    w = {n, ~s6};
    k = -1;
    for (int i = 6; i >= 0; i--) if (w[i] && k < 0) k = i;
    bad = 1'b0;
    m = '0;
    if (k < 1) begin bad = 1'b1; return; end
    e = 1 << k;
    s = int'(s6) % e;
    r = int'(r6) % e;
    if (s == e - 1) begin bad = 1'b1; return; end
    for (int i = 0; i < 64; i++) m[i] = (((i % e) + r) % e) <= s;
  endtask

  task automatic check(input string tag, input logic eb, input logic [63:0] em,
                       input logic ev);
    checks++;
    if (bad_enc_o !== eb || mask_o !== em || out_vld !== ev) begin
      errors++;
      $display("FAIL %s: got bad=%0b mask=%h vld=%0b expected bad=%0b mask=%h vld=%0b",
               tag, bad_enc_o, mask_o, out_vld, eb, em, ev);
    end
  endtask

  task automatic drive(input logic v, input logic n, input logic [5:0] s6,
                       input logic [5:0] r6);
    in_vld = v; wide_sel = n; run_fld = s6; rot_fld = r6;
  endtask

  initial begin
    logic eb;
    logic [63:0] em;
    repeat (3) @(negedge clk);
    check("R7 reset", 1'b0, 64'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][77], VEC[i][76:71], VEC[i][70:65]);
      @(negedge clk);
      check(tag_of(i), VEC[i][64], VEC[i][63:0], 1'b1);
    end

    // R6: one-cycle latency and valid drop
    drive(1'b0, 1'b1, 6'd0, 6'd0);
    @(negedge clk);
    check("R6 vld low", 1'b0, 64'h1, 1'b0);
    drive(1'b1, 1'b0, 6'b111100, 6'd1);
    check("R6 no early change", 1'b0, 64'h1, 1'b0);
    @(negedge clk);
    check("R6 one cycle", 1'b0, 64'hAAAAAAAAAAAAAAAA, 1'b1);

    // R8: high rotate bits have no effect for an 8-bit element
    drive(1'b1, 1'b0, 6'b110011, 6'b111000);
    @(negedge clk);
    check("R8 high rot ignored", 1'b0, 64'h0F0F0F0F0F0F0F0F, 1'b1);

    // exhaustive sweep: R1 R2 R3 R4 R5
    for (int c = 0; c < 8192; c++) begin
      logic [12:0] cv;
      cv = 13'(c);
      drive(1'b1, cv[12], cv[11:6], cv[5:0]);
      model(cv[12], cv[11:6], cv[5:0], eb, em);
      @(negedge clk);
      check("R4 sweep", eb, em, 1'b1);
    end

    // R7: reset in the middle of traffic
    drive(1'b1, 1'b1, 6'b111110, 6'd1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7 mid reset", 1'b0, 64'h0, 1'b0);
    @(negedge clk);
    check("R7 held", 1'b0, 64'h0, 1'b0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule